// File: doc/BRIEF.md
# Converter Result Register Pair with Read Lock

This block stores the 10-bit value produced by an analog-to-digital converter and lets software fetch it over an 8-bit bus as two byte registers. One address selects the low byte and the other selects the high byte. A single alignment input chooses how the 10 bits sit inside the 16-bit pair. Right adjustment keeps the value in the low-order bits. Left adjustment packs it toward the top, so that the high byte alone carries an 8-bit reading, and for a signed differential result it also carries the sign.

Software that needs the full value must read the low byte before the high byte. The low-byte read freezes the pair, and a conversion that finishes during the freeze is discarded, so the two bytes always come from the same sample. Reading the high byte ends the freeze. Software that only needs 8 bits of a left-adjusted value can read the high byte by itself and never leaves the pair frozen.

Top module: `conv_result_regs`

## Requirements
- R1: After reset the stored value is zero, so both byte addresses read 0x00 under either alignment.
- R2: When the pair is unlocked, a `done_i` pulse stores `sample_i` at that clock edge, and the new value is readable in the next cycle.
- R3: With `align_left_i` = 0, address 1 (high byte) reads {6'b0, value[9:8]} and address 0 (low byte) reads value[7:0].
- R4: With `align_left_i` = 1, address 1 reads value[9:2] and address 0 reads {value[1:0], 6'b0}.
- R5: A read strobe (`rd_i` = 1) at address 0 locks the pair. While it is locked, every `done_i` pulse is dropped and its value is lost.
- R6: A read strobe at address 1 clears the lock at the end of that cycle. A `done_i` in that same cycle is still dropped, and a `done_i` in the following cycle is stored.
- R7: A read strobe at address 1 with no earlier address-0 read returns the current data and leaves the pair unlocked, so the next `done_i` is stored.
- R8: Alignment is applied when the value is read, not when it is stored. Changing `align_left_i` changes the read data of a value that is already stored.
- R9: A `done_i` pulse in the same cycle as an address-0 read strobe is dropped, so the low byte just returned and the high byte read later come from the same value.
- R10: With left alignment, value bit 9 (the sign of a two's complement differential result) appears at bit 7 of the high byte. For example, 10'h200 reads 0x80 at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Conversion-complete strobe, one cycle |
| sample_i | input | 10 | Conversion value qualified by done_i |
| align_left_i | input | 1 | 1 selects left adjustment, 0 selects right adjustment |
| rd_i | input | 1 | Byte read strobe |
| rd_addr_i | input | 1 | Byte select: 0 selects the low byte, 1 selects the high byte |
| rd_data_o | output | 8 | Combinational read data of the selected byte |

## Verification
The bench checks that the lock survives conversions arriving while it is held. A design without the lock would return a high byte from a newer sample than the low byte. The bench also probes the cycle boundaries. A `done_i` that coincides with the low-byte read or with the unlocking high-byte read must be lost. The `done_i` one cycle later must be taken. An off-by-one in the lock timing shows up as a stored value the bench does not expect. Other checks cover a high-byte-only read that wrongly locks the pair, and alignment latched at capture instead of applied at read. Both of these show up as a wrong byte layout, or as a result that never appears.

// File: rtl/cres_pkg.sv
package cres_pkg;
   typedef enum logic {
      SEL_LOW  = 1'b0,
      SEL_HIGH = 1'b1
   } byte_sel_e;
endpackage

// File: rtl/cres_lock_ctl.sv
module cres_lock_ctl
   import cres_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_i,
   input  byte_sel_e sel_i,
   input  logic      done_i,
   output logic      lock_o,
   output logic      take_o
);
   logic lock_q;
   logic rd_low, rd_high;

   assign rd_low  = rd_i && (sel_i == SEL_LOW);
   assign rd_high = rd_i && (sel_i == SEL_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= 1'b0;
      else if (rd_low)  lock_q <= 1'b1;
      else if (rd_high) lock_q <= 1'b0;
   end

   // a result is accepted only when no frozen read is in progress or starting
   assign take_o = done_i && !lock_q && !rd_low;
   assign lock_o = lock_q;
endmodule

// File: rtl/cres_store.sv
module cres_store #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [RES_W-1:0] sample_i,
   output logic [RES_W-1:0] raw_o
);
   logic [RES_W-1:0] raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw_q <= '0;
      else if (take_i) raw_q <= sample_i;
   end

   assign raw_o = raw_q;
endmodule

// File: rtl/cres_align_mux.sv
module cres_align_mux
   import cres_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic [RES_W-1:0] raw_i,
   input  logic             align_left_i,
   input  byte_sel_e        sel_i,
   output logic [BUS_W-1:0] data_o
);
   localparam int PAIR_W = 2 * BUS_W;
   localparam int PAD_W  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] pair;
   logic [BUS_W-1:0]  bytes [2];

   generate
      if (PAD_W == 0) begin : g_full
         // value fills the pair, both layouts coincide
         assign pair = raw_i;
      end else begin : g_pad
         logic [PAIR_W-1:0] right_v, left_v;
         assign right_v = {{PAD_W{1'b0}}, raw_i};
         assign left_v  = {raw_i, {PAD_W{1'b0}}};
         assign pair    = align_left_i ? left_v : right_v;
      end
   endgenerate

   for (genvar g = 0; g < 2; g++) begin : g_bytes
      assign bytes[g] = pair[g*BUS_W +: BUS_W];
   end

   assign data_o = (sel_i == SEL_HIGH) ? bytes[1] : bytes[0];

   if (PAD_W == 0) begin : g_unused
      logic unused_align;
      assign unused_align = align_left_i;
   end
endmodule

// File: rtl/conv_result_regs.sv
module conv_result_regs
   import cres_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [RES_W-1:0] sample_i,
   input  logic             align_left_i,
   input  logic             rd_i,
   input  logic             rd_addr_i,
   output logic [BUS_W-1:0] rd_data_o
);
   generate
      if (RES_W <= BUS_W || RES_W > 2 * BUS_W) begin : g_bad_width
         $error("conv_result_regs: RES_W must exceed BUS_W and fit in two bytes");
      end
   endgenerate

   byte_sel_e        sel;
   logic             lock_q;
   logic             take;
   logic [RES_W-1:0] raw_q;

   assign sel = byte_sel_e'(rd_addr_i);

   cres_lock_ctl u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_i   (rd_i),
      .sel_i  (sel),
      .done_i (done_i),
      .lock_o (lock_q),
      .take_o (take)
   );

   cres_store #(.RES_W(RES_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take),
      .sample_i (sample_i),
      .raw_o    (raw_q)
   );

   cres_align_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
      .raw_i        (raw_q),
      .align_left_i (align_left_i),
      .sel_i        (sel),
      .data_o       (rd_data_o)
   );
endmodule

// File: rtl/conv_result_regs_chk.sv
module conv_result_regs_chk #(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_i,
   input logic [RES_W-1:0] sample_i,
   input logic             align_left_i,
   input logic             rd_i,
   input logic             rd_addr_i,
   input logic [BUS_W-1:0] rd_data_o,
   input logic             lock_q,
   input logic [RES_W-1:0] raw_q
);
   localparam int PAD_W = 2 * BUS_W - RES_W;
   localparam logic [BUS_W-1:0] LOW_MASK = BUS_W'((32'd1 << PAD_W) - 32'd1);

   AST_CAPTURE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && !lock_q && !(rd_i && !rd_addr_i) |=> raw_q == $past(sample_i)); // R2
   AST_RIGHT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !align_left_i && rd_addr_i |-> (rd_data_o >> (RES_W - BUS_W)) == '0); // R3
   AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      align_left_i && !rd_addr_i |-> (rd_data_o & LOW_MASK) == '0); // R4
   AST_LOW_READ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && !rd_addr_i |=> lock_q); // R5
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(raw_q)); // R5
   AST_HIGH_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && rd_addr_i |=> !lock_q); // R6
   AST_SAME_CYCLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && rd_i && !rd_addr_i |=> $stable(raw_q)); // R9
endmodule

bind conv_result_regs conv_result_regs_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .done_i       (done_i),
   .sample_i     (sample_i),
   .align_left_i (align_left_i),
   .rd_i         (rd_i),
   .rd_addr_i    (rd_addr_i),
   .rd_data_o    (rd_data_o),
   .lock_q       (lock_q),
   .raw_q        (raw_q)
);

// File: tb/conv_result_regs_tb_top.sv
module conv_result_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_i = 1'b0;
   logic [9:0] sample_i = '0;
   logic       align_left_i = 1'b0;
   logic       rd_i = 1'b0;
   logic       rd_addr_i = 1'b0;
   logic [7:0] rd_data_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   conv_result_regs dut_i (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .sample_i(sample_i),
      .align_left_i(align_left_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o)
   );

   function automatic logic [7:0] fmt(logic [9:0] v, logic al, logic a);
      logic [15:0] p;
      p = al ? {v, 6'b0} : {6'b0, v};
      return a ? p[15:8] : p[7:0];
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // look at a byte without a read strobe
   task automatic peek(string req, logic a, logic [9:0] v);
      rd_i = 1'b0; rd_addr_i = a; #1;
      chk(req, rd_data_o, fmt(v, align_left_i, a));
   endtask

   // one-cycle read strobe; data checked during the strobe
   task automatic rd(string req, logic a, logic [9:0] v);
      @(negedge clk); rd_i = 1'b1; rd_addr_i = a; #1;
      chk(req, rd_data_o, fmt(v, align_left_i, a));
      @(negedge clk); rd_i = 1'b0;
   endtask

   task automatic conv(logic [9:0] v);
      @(negedge clk); done_i = 1'b1; sample_i = v;
      @(negedge clk); done_i = 1'b0;
   endtask

   task automatic t_reset;
      align_left_i = 1'b0; peek("R1", 1'b0, 10'h0); peek("R1", 1'b1, 10'h0);
      align_left_i = 1'b1; peek("R1", 1'b0, 10'h0); peek("R1", 1'b1, 10'h0);
   endtask

   task automatic t_right;
      align_left_i = 1'b0;
      conv(10'h2A5);
      chk("R3", fmt(10'h2A5, 1'b0, 1'b1), 8'h02);
      rd("R2 R3", 1'b0, 10'h2A5);
      rd("R2 R3", 1'b1, 10'h2A5);
   endtask

   task automatic t_left;
      align_left_i = 1'b1;
      conv(10'h2A5);
      peek("R4", 1'b1, 10'h2A5); chk("R4", rd_data_o, 8'hA9);
      peek("R4", 1'b0, 10'h2A5); chk("R4", rd_data_o, 8'h40);
   endtask

   task automatic t_sign;
      align_left_i = 1'b1;
      conv(10'h200);
      peek("R10", 1'b1, 10'h200); chk("R10", rd_data_o, 8'h80);
   endtask

   task automatic t_lock;
      align_left_i = 1'b0;
      conv(10'h0F3);
      rd("R5", 1'b0, 10'h0F3);
      conv(10'h155);
      conv(10'h2C8);
      rd("R5", 1'b1, 10'h0F3);
      peek("R5", 1'b0, 10'h0F3);
      conv(10'h31C);
      peek("R6", 1'b0, 10'h31C);
   endtask

   task automatic t_unlock_edge;
      align_left_i = 1'b0;
      rd("R6", 1'b0, 10'h31C);
      @(negedge clk); rd_i = 1'b1; rd_addr_i = 1'b1; done_i = 1'b1; sample_i = 10'h3FF;
      @(negedge clk); rd_i = 1'b0; done_i = 1'b0;
      peek("R6", 1'b0, 10'h31C);
      done_i = 1'b1; sample_i = 10'h011;
      @(negedge clk); done_i = 1'b0;
      peek("R6", 1'b0, 10'h011);
      peek("R6", 1'b1, 10'h011);
   endtask

   task automatic t_high_only;
      align_left_i = 1'b1;
      conv(10'h1E4);
      rd("R7", 1'b1, 10'h1E4);
      conv(10'h123);
      peek("R7", 1'b1, 10'h123);
      rd("R7", 1'b1, 10'h123);
      conv(10'h0B6);
      peek("R7", 1'b0, 10'h0B6);
   endtask

   task automatic t_realign;
      align_left_i = 1'b0; conv(10'h2D7);
      align_left_i = 1'b1;
      peek("R8", 1'b1, 10'h2D7); peek("R8", 1'b0, 10'h2D7);
      align_left_i = 1'b0;
      peek("R8", 1'b1, 10'h2D7); peek("R8", 1'b0, 10'h2D7);
   endtask

   task automatic t_same_cycle;
      align_left_i = 1'b0;
      @(negedge clk); rd_i = 1'b1; rd_addr_i = 1'b0; done_i = 1'b1; sample_i = 10'h0AA; #1;
      chk("R9", rd_data_o, fmt(10'h2D7, 1'b0, 1'b0));
      @(negedge clk); rd_i = 1'b0; done_i = 1'b0;
      rd("R9", 1'b1, 10'h2D7);
      peek("R9", 1'b0, 10'h2D7);
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_right();
      t_left();
      t_sign();
      t_lock();
      t_unlock_edge();
      t_high_only();
      t_realign();
      t_same_cycle();
      repeat (2) @(negedge clk);
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
   end
endmodule